// File: doc/BRIEF.md
# Status Snapshot Bank

This block keeps four 8-bit status bytes for a serially accessed device. In each byte, bits 6..0 come from internal condition inputs and bit 7 is an odd-count parity bit over those seven bits. A host reads the bytes one frame at a time. The serial shifter sits outside this block. It presents the bytes to the host and reports each read through a strobe and an address.

Two of the bytes collect fault events. Once a fault bit is set it stays set until the host has read that byte. The other two bytes follow their inputs directly. One of the direct bytes also carries a sticky watchdog flag, which only an explicit clear request can reset. Nothing in the bank changes while the chip select is low, so a frame always sees one stable snapshot. An active-low error line reports whether any collected fault is still held.

Top module: `stat_snap_bank`

## Requirements
- R1: After a synchronous reset all four bytes on `stat_o` are 0 and `err_n` is 1.
- R2: Bit 7 of every byte is 1 when bits 6..0 hold an odd number of ones and 0 otherwise. Byte k sits at `stat_o[8k+7:8k]` and is mapped to address 04h+k.
- R3: Bytes 0 (04h) and 3 (07h) take their inputs `cond_in[7k+6:7k]` at every clock edge where `cs_n` is 1. The new value is visible after that edge.
- R4: Bytes 1 (05h) and 2 (06h) OR their event inputs into the stored bits at every edge where `cs_n` is 1. A bit stays set after its input returns to 0.
- R5: While `cs_n` is 0, every byte and `err_n` hold their values, whatever the condition, watchdog and strobe inputs do.
- R6: A pulse of `rd_stb` with `rd_addr` equal to 05h or 06h marks that byte for clearing. At the first later edge where `cs_n` is 1, the byte is cleared.
- R7: On the clearing edge, event bits present in that same cycle win over the clear: the byte becomes exactly that cycle's event bits.
- R8: `err_n` is 0 exactly when some bit 6..0 of byte 1 or byte 2 is set. It changes on the same edge as those bytes.
- R9: Bit 2 of byte 0 is a watchdog flag, and the input `cond_in[2]` is ignored for this bit. The flag is set by `wd_evt` and cleared by `wd_clr`, with set winning over clear. Both take effect only at edges where `cs_n` is 1.
- R10: Reads of 04h, of 07h or of addresses outside 04h..07h clear nothing. A read never clears the watchdog flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low; updates only while high |
| rd_stb | input | 1 | One-cycle pulse per completed host read |
| rd_addr | input | 5 | Address of the byte that was read |
| cond_in | input | 28 | Condition bits, 7 per byte, byte k at [7k+6:7k] |
| wd_evt | input | 1 | Sets the watchdog flag |
| wd_clr | input | 1 | Clears the watchdog flag |
| stat_o | output | 32 | Four status bytes with parity, byte k at [8k+7:8k] |
| err_n | output | 1 | Low while any collected fault is held |

## Verification
Two collisions matter in this block. The first is the deferred clear of a fault byte landing on the same edge as a fresh event. The bench provokes it by reading 06h with the chip select low, then raising the select while a new event bit is applied. The byte must hold only the new bit, with no trace of the old ones, and must keep that bit on the following edges. The second is a watchdog set arriving in the same cycle as a clear request. The bench drives both together and expects the flag to survive, then drives the clear alone and expects the flag to drop.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int STAT_W    = 7;
  localparam int BYTE_W    = STAT_W + 1;
  localparam int REG_N     = 4;
  localparam int ADR_W     = 5;
  localparam int FIRST_ADR = 4;
endpackage

// File: rtl/ssb_parity.sv
module ssb_parity #(
  parameter int W = ssb_pkg::STAT_W
) (
  input  logic [W-1:0] bits_i,
  output logic [W:0]   byte_o
);
  // odd number of ones gives a set top bit
  assign byte_o = {^bits_i, bits_i};
endmodule

// File: rtl/ssb_latch_reg.sv
module ssb_latch_reg #(
  parameter int W = ssb_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         hit,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;
  logic         pend;

  always_comb begin
    nxt_o = q;
    if (upd) nxt_o = pend ? evt : (q | evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      pend <= 1'b0;
    end else begin
      q    <= nxt_o;
      pend <= upd ? hit : (pend | hit);
    end
  end

  assign q_o = q;

  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q_o));
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (upd && !pend) |=> ((q_o & $past(q_o)) == $past(q_o)));
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (upd && pend) |=> (q_o == $past(evt)));
  assert_read_marks_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd && hit) |=> pend);
endmodule

// File: rtl/ssb_live_reg.sv
module ssb_live_reg #(
  parameter int W          = ssb_pkg::STAT_W,
  parameter bit STICKY_EN  = 1'b0,
  parameter int STICKY_BIT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] din,
  input  logic         set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP = STICKY_EN ? ~(W'(1) << STICKY_BIT) : '1;

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd) begin
      q <= din;
      if (STICKY_EN) q[STICKY_BIT] <= set_i | (q[STICKY_BIT] & ~clr_i);
    end
  end

  assign q_o = q;

  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(q_o));
  assert_follow_R3: assert property (@(posedge clk) disable iff (rst)
    upd |=> ((q_o & KEEP) == ($past(din) & KEEP)));

  if (STICKY_EN) begin : g_wd_chk
    assert_wd_set_R9: assert property (@(posedge clk) disable iff (rst)
      (upd && set_i) |=> q_o[STICKY_BIT]);
    assert_wd_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (q_o[STICKY_BIT] && !(upd && clr_i)) |=> q_o[STICKY_BIT]);
  end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank #(
  parameter int                 W          = ssb_pkg::STAT_W,
  parameter int                 NREG       = ssb_pkg::REG_N,
  parameter int                 AW         = ssb_pkg::ADR_W,
  parameter int                 BASE       = ssb_pkg::FIRST_ADR,
  parameter logic [NREG-1:0]    LATCH_MASK = 4'b0110,
  parameter int                 WD_REG     = 0,
  parameter int                 WD_BIT     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  rd_stb,
  input  logic [AW-1:0]         rd_addr,
  input  logic [NREG*W-1:0]     cond_in,
  input  logic                  wd_evt,
  input  logic                  wd_clr,
  output logic [NREG*(W+1)-1:0] stat_o,
  output logic                  err_n
);
  localparam int BW = W + 1;

  logic             upd;
  logic [W-1:0]     q_arr   [NREG];
  logic [W-1:0]     nxt_arr [NREG];
  logic [NREG*W-1:0] lat_q_flat;
  logic [NREG*W-1:0] lat_n_flat;
  logic             err_n_q;

  assign upd = cs_n;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] MY_ADR = AW'(BASE + i);

    if (LATCH_MASK[i]) begin : g_lat
      logic hit;
      assign hit = rd_stb && (rd_addr == MY_ADR);
      ssb_latch_reg #(.W(W)) u_lat (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .hit   (hit),
        .evt   (cond_in[i*W +: W]),
        .q_o   (q_arr[i]),
        .nxt_o (nxt_arr[i])
      );
      assign lat_q_flat[i*W +: W] = q_arr[i];
      assign lat_n_flat[i*W +: W] = nxt_arr[i];
    end else begin : g_live
      ssb_live_reg #(
        .W          (W),
        .STICKY_EN  (i == WD_REG),
        .STICKY_BIT (WD_BIT)
      ) u_live (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .din   (cond_in[i*W +: W]),
        .set_i (wd_evt),
        .clr_i (wd_clr),
        .q_o   (q_arr[i])
      );
      assign nxt_arr[i]             = '0;
      assign lat_q_flat[i*W +: W]   = '0;
      assign lat_n_flat[i*W +: W]   = '0;
    end

    ssb_parity #(.W(W)) u_par (
      .bits_i (q_arr[i]),
      .byte_o (stat_o[i*BW +: BW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)      err_n_q <= 1'b1;
    else if (upd) err_n_q <= ~|lat_n_flat;
  end

  assign err_n = err_n_q;

  assert_err_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    err_n == !(|lat_q_flat));
  assert_err_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> $stable(err_n));
endmodule

// File: tb/sim_stat_snap_bank.sv
`timescale 1ns/1ps
module sim_stat_snap_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_stb = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [27:0] cond_in = '0;
  logic        wd_evt = 1'b0;
  logic        wd_clr = 1'b0;
  logic [31:0] stat_o;
  logic        err_n;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  stat_snap_bank u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .cond_in(cond_in), .wd_evt(wd_evt), .wd_clr(wd_clr),
    .stat_o(stat_o), .err_n(err_n)
  );

  function automatic logic [7:0] pb(input logic [6:0] v);
    return {^v, v};
  endfunction

  function automatic logic [7:0] byt(input int k);
    return stat_o[k*8 +: 8];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setc(input int k, input logic [6:0] v);
    cond_in[k*7 +: 7] = v;
  endtask

  task automatic host_read(input logic [4:0] a);
    rd_stb = 1'b1; rd_addr = a;
    step();
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 bytes", stat_o, 32'h0);
    chk("R1 err_n", {31'b0, err_n}, 32'h1);
  endtask

  task automatic t_live();
    cs_n = 1'b1;
    setc(0, 7'h51); setc(3, 7'h7F);
    step();
    chk("R3 R2 byte0", byt(0), 8'hD1);
    chk("R3 R2 byte3", byt(3), 8'hFF);
    setc(3, 7'h06);
    step();
    chk("R3 R2 byte3 even", byt(3), 8'h06);
    setc(0, 7'h00); setc(3, 7'h00);
    step();
  endtask

  task automatic t_accum();
    setc(1, 7'h01); step();
    setc(1, 7'h10); step();
    setc(1, 7'h00); step();
    chk("R4 byte1 held", byt(1), 8'h11);
    chk("R8 err low", {31'b0, err_n}, 32'h0);
  endtask

  task automatic t_freeze();
    logic [31:0] snap;
    snap = stat_o;
    cs_n = 1'b0;
    setc(0, 7'h2A); setc(2, 7'h7F); setc(3, 7'h33);
    wd_evt = 1'b1;
    step(); step();
    wd_evt = 1'b0;
    host_read(5'd5);
    step();
    chk("R5 frozen bytes", stat_o, snap);
    chk("R5 frozen err", {31'b0, err_n}, 32'h0);
    setc(0, 7'h00); setc(2, 7'h00); setc(3, 7'h00);
  endtask

  task automatic t_readclr();
    // read of 05h was recorded during t_freeze; clear on first select-high edge
    cs_n = 1'b1;
    step();
    chk("R6 byte1 cleared", byt(1), 8'h00);
    chk("R8 err released", {31'b0, err_n}, 32'h1);
  endtask

  task automatic t_race();
    setc(2, 7'h03); step(); setc(2, 7'h00);
    chk("R4 byte2 set", byt(2), 8'h03);
    cs_n = 1'b0;
    host_read(5'd6);
    setc(2, 7'h40); cs_n = 1'b1;
    step();
    chk("R7 event beats clear", byt(2), 8'hC0);
    setc(2, 7'h00); step();
    chk("R7 no second clear", byt(2), 8'hC0);
    chk("R8 err held", {31'b0, err_n}, 32'h0);
    host_read(5'd6); step();
    chk("R6 byte2 cleared", byt(2), 8'h00);
  endtask

  task automatic t_noclr();
    setc(1, 7'h08); step(); setc(1, 7'h00);
    cs_n = 1'b0;
    host_read(5'd4); host_read(5'd7); host_read(5'd8); host_read(5'd3);
    cs_n = 1'b1;
    step(); step();
    chk("R10 byte1 kept", byt(1), 8'h88);
    host_read(5'd5); step();
    chk("R6 byte1 cleared again", byt(1), 8'h00);
  endtask

  task automatic t_wd();
    setc(0, 7'h04); step();
    chk("R9 input bit ignored", byt(0), 8'h00);
    setc(0, 7'h00);
    wd_evt = 1'b1; step(); wd_evt = 1'b0;
    chk("R9 wd set", byt(0), 8'h84);
    host_read(5'd4); step();
    chk("R10 wd kept after read", byt(0), 8'h84);
    wd_evt = 1'b1; wd_clr = 1'b1; step();
    chk("R9 set beats clear", byt(0), 8'h84);
    wd_evt = 1'b0; step();
    wd_clr = 1'b0;
    chk("R9 wd cleared", byt(0), 8'h00);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    report();
  end

  initial begin
    step(); step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_live();
    t_accum();
    t_freeze();
    t_readclr();
    t_race();
    t_noclr();
    t_wd();
    report();
  end
endmodule